// File: doc/BRIEF.md
# Time-Space-Time Switching Fabric

This block switches byte-wide time-division streams between a set of ports. Every input port feeds its own input time-slot interchanger, which moves each external slot onto a chosen slot of an internal link. A crosspoint stage connects input links to output links separately for each internal slot. An output time-slot interchanger on each output link then places the internal slot onto the requested external output slot. Internal slot numbers have no fixed relation to external slot numbers. With `NLINK` internal slots and `NSLOT` external slots, the default `NLINK = 2*NSLOT - 1` makes the fabric strictly nonblocking.

The fabric runs on a single clock. One frame lasts `NLINK` clock cycles. External slots occupy frame positions 0 to `NSLOT-1`, and the remaining positions carry no external data. The internal stage uses every position of the frame, so it runs `NLINK/NSLOT` times faster than the external slot rate. Each speech memory has two banks, selected by frame parity, which gives a fixed transit of two frames.

A host sets up paths with a one-cycle command. A connect command names the input port and slot, the output port and slot, and either a chosen internal slot or a request for automatic search. A disconnect command names only the output port and slot. Every command returns a status and the internal slot that was used.

Top module: `tst_switch`

## Requirements
- R1: `in_fs` marks frame position 0. Without `in_fs`, the position counter runs freely through `NLINK` positions per frame. `out_fs` goes high exactly one cycle after each cycle at frame position 0, whether that position came from `in_fs` or from the counter wrapping.
- R2: A byte entering on input port p in slot s during frame n appears on the connected output port in frame n+2. It is driven in the cycle after the frame position equal to the output slot number.
- R3: An explicit connect may use any internal slot from 0 to `NLINK-1`, whatever the external slot numbers are.
- R4: An explicit connect whose internal slot is already busy on the inlet link or on the outlet link returns status 1 (blocked). It changes no path, and the named output slot keeps its previous content.
- R5: A connect with `cmd_auto`=1 takes the lowest-numbered internal slot that is idle on both the inlet link and the outlet link, and reports that slot in `rsp_int_slot` with status 0 (ok).
- R6: A connect with `cmd_auto`=1 returns status 1 (blocked) when no internal slot is idle on both links, and the output slot stays idle.
- R7: A connect to an output slot that is already in use returns status 2. The existing path on that slot is unaffected.
- R8: A disconnect of a busy output slot returns status 0 with the freed internal slot. It frees that internal slot on both links, and the output slot returns to idle. A disconnect of an idle output slot returns status 3.
- R9: Idle output slots and frame positions at or above `NSLOT` carry the idle byte 0xFF. During reset, `out_data` is 0xFF and `out_fs` and `rsp_vld` are 0.
- R10: `rsp_vld` is high for exactly one cycle, in the cycle after each command cycle (`cmd_op` 0 = connect, 1 = disconnect).
- R11: With `NLINK = 2*NSLOT - 1`, a connect succeeds even when `NSLOT-1` internal slots are busy on its inlet link and a disjoint set of `NSLOT-1` internal slots is busy on its outlet link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, one internal slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| in_fs | input | 1 | Frame start: this cycle is frame position 0 |
| in_data | input | NPORT*DW | Input bytes, one per port, for the current position |
| out_fs | output | 1 | Frame start of the output streams, one cycle after position 0 |
| out_data | output | NPORT*DW | Output bytes, one per port |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 connect, 1 disconnect |
| cmd_auto | input | 1 | Search for the internal slot instead of using cmd_int_slot |
| cmd_in_port | input | log2(NPORT) | Inlet port |
| cmd_in_slot | input | log2(NSLOT) | Inlet external slot |
| cmd_out_port | input | log2(NPORT) | Outlet port |
| cmd_out_slot | input | log2(NSLOT) | Outlet external slot |
| cmd_int_slot | input | log2(NLINK) | Requested internal slot |
| rsp_vld | output | 1 | Response strobe |
| rsp_status | output | 2 | 0 ok, 1 blocked, 2 output slot in use, 3 not connected |
| rsp_int_slot | output | log2(NLINK) | Internal slot used or freed |

## Verification
The bench targets the worst case for strict nonblocking. Seven slots are loaded on the inlet link and seven other slots on the outlet link, so only internal slot 14 remains; a search that stops early or counts wrongly returns blocked. The bench fills every internal slot of one link through multicast to show a true block. It then checks that refused commands leave both the existing output data and the idle outputs untouched, which a design that writes the tables before validating the command would corrupt. Disconnect is checked by reconnecting through both freed links; a design that frees only one side would hand out internal slot 1 instead of 0. Data checks use frame-tagged bytes, so a bank-parity slip shows up as the wrong frame number.

// File: rtl/tst_pkg.sv
// Shared encodings for the time-space-time fabric.
// Assumes: the command interface uses a single-bit opcode.
package tst_pkg;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_BLOCKED  = 2'd1,
        ST_OUT_BUSY = 2'd2,
        ST_NOT_CONN = 2'd3
    } tst_status_e;

    localparam logic OP_CONNECT    = 1'b0;
    localparam logic OP_DISCONNECT = 1'b1;

endpackage

// File: rtl/tst_in_tsi.sv
// Input time-slot interchanger for one port.
// Writes external slots in arrival order into the bank chosen by the frame
// parity, and reads the other bank at a random address set by the control
// tables. Assumes: ph flips at frame position 0.
module tst_in_tsi #(
    parameter int NSLOT = 8,
    parameter int DW    = 8,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          ph,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] rd_addr,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] mem [2][NSLOT];

    // capture the arriving external slot in the current-frame bank
    always_ff @(posedge clk) begin : seq_write
        if (wr_en) begin
            mem[ph][wr_slot] <= din;
        end
    end

    // random read from the bank filled during the previous frame
    always_comb begin : rand_read
        dout = mem[~ph][rd_addr];
    end

endmodule

// File: rtl/tst_space.sv
// Crosspoint stage: for the current internal slot, each output link takes
// the input link named by its select, or zero when its gate is closed.
// Assumes: NPORT is a power of two.
module tst_space #(
    parameter int NPORT = 4,
    parameter int DW    = 8,
    localparam int PTW  = $clog2(NPORT)
) (
    input  logic [NPORT-1:0][DW-1:0]  link_in,
    input  logic [NPORT-1:0][PTW-1:0] sel,
    input  logic [NPORT-1:0]          en,
    output logic [NPORT-1:0][DW-1:0]  link_out
);

    // one gated multiplexer per output link
    always_comb begin : xpoint
        for (int q = 0; q < NPORT; q++) begin
            link_out[q] = en[q] ? link_in[sel[q]] : '0;
        end
    end

endmodule

// File: rtl/tst_out_tsi.sv
// Output time-slot interchanger for one port.
// Writes internal slots at random addresses (the external output slot)
// into the current-frame bank, and reads the other bank in slot order.
// Idle slots and positions beyond the external frame yield IDLE_BYTE.
module tst_out_tsi #(
    parameter int NSLOT              = 8,
    parameter int DW                 = 8,
    parameter logic [DW-1:0] IDLE_BYTE = '1,
    localparam int SW                = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_act,
    input  logic [SW-1:0] rd_slot,
    input  logic          slot_busy,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] mem [2][NSLOT];
    logic [DW-1:0] rd_byte;

    // place the switched byte at its external output slot
    always_ff @(posedge clk) begin : rand_write
        if (wr_en) begin
            mem[ph][wr_addr] <= wr_data;
        end
    end

    // sequential read of the bank written in the previous frame
    always_comb begin : seq_read
        rd_byte = mem[~ph][rd_slot];
    end

    // register the output byte, substituting the idle pattern
    always_ff @(posedge clk) begin : out_reg
        if (!rst_n) begin
            dout <= IDLE_BYTE;
        end else begin
            dout <= (rd_act && slot_busy) ? rd_byte : IDLE_BYTE;
        end
    end

endmodule

// File: rtl/tst_ctrl.sv
// Control tables and command engine.
// Holds per-link busy maps for inlet and outlet links, the inlet slot for
// each internal slot, the crosspoint source and outlet slot for each
// internal slot, and the internal slot carrying each external output slot.
// Connect checks the output slot, then either validates the requested
// internal slot or searches for the lowest slot idle on both links.
// Assumes: port and external slot fields are always in range.
module tst_ctrl
    import tst_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NSLOT = 8,
    parameter int NLINK = 15,
    localparam int PTW  = $clog2(NPORT),
    localparam int SW   = $clog2(NSLOT),
    localparam int KW   = $clog2(NLINK)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_vld,
    input  logic                       cmd_op,
    input  logic                       cmd_auto,
    input  logic [PTW-1:0]             cmd_in_port,
    input  logic [SW-1:0]              cmd_in_slot,
    input  logic [PTW-1:0]             cmd_out_port,
    input  logic [SW-1:0]              cmd_out_slot,
    input  logic [KW-1:0]              cmd_int_slot,
    input  logic [KW-1:0]              pos,
    output logic [NPORT-1:0][SW-1:0]   rd_addr,
    output logic [NPORT-1:0]           xp_en,
    output logic [NPORT-1:0][PTW-1:0]  xp_sel,
    output logic [NPORT-1:0][SW-1:0]   wr_addr,
    output logic [NPORT-1:0][NSLOT-1:0] oslot_busy,
    output logic                       rsp_vld,
    output logic [1:0]                 rsp_status,
    output logic [KW-1:0]              rsp_int_slot
);

    logic [NPORT-1:0][NLINK-1:0] ib_q;
    logic [NPORT-1:0][NLINK-1:0] ob_q;
    logic [NPORT-1:0][NSLOT-1:0] mb_q;
    logic [SW-1:0]  isl_q [NPORT][NLINK];
    logic [PTW-1:0] opt_q [NPORT][NLINK];
    logic [SW-1:0]  osl_q [NPORT][NLINK];
    logic [KW-1:0]  mk_q  [NPORT][NSLOT];

    logic [NLINK-1:0] free;
    logic             hunt_hit;
    logic [KW-1:0]    hunt_k;
    logic             man_ok;
    logic             do_conn;
    logic             do_disc;
    logic [KW-1:0]    sel_k;
    logic [KW-1:0]    disc_k;
    logic [PTW-1:0]   disc_p;
    tst_status_e      st;

    // internal slots idle on both links, lowest-first search, manual check
    always_comb begin : hunt
        free     = '0;
        hunt_hit = 1'b0;
        hunt_k   = '0;
        man_ok   = 1'b0;
        for (int k = 0; k < NLINK; k++) begin
            free[k] = !ib_q[cmd_in_port][k] && !ob_q[cmd_out_port][k];
        end
        for (int k = NLINK - 1; k >= 0; k--) begin
            if (free[k]) begin
                hunt_hit = 1'b1;
                hunt_k   = KW'(k);
            end
        end
        for (int k = 0; k < NLINK; k++) begin
            if (cmd_int_slot == KW'(k)) begin
                man_ok = free[k];
            end
        end
    end

    // decide the outcome of the presented command
    always_comb begin : decide
        do_conn = 1'b0;
        do_disc = 1'b0;
        st      = ST_OK;
        disc_k  = mk_q[cmd_out_port][cmd_out_slot];
        disc_p  = opt_q[cmd_out_port][disc_k];
        sel_k   = cmd_auto ? hunt_k : cmd_int_slot;
        if (cmd_op == OP_CONNECT) begin
            if (mb_q[cmd_out_port][cmd_out_slot]) begin
                st = ST_OUT_BUSY;
            end else if (cmd_auto ? !hunt_hit : !man_ok) begin
                st = ST_BLOCKED;
            end else begin
                do_conn = cmd_vld;
            end
        end else begin
            sel_k = disc_k;
            if (!mb_q[cmd_out_port][cmd_out_slot]) begin
                st = ST_NOT_CONN;
            end else begin
                do_disc = cmd_vld;
            end
        end
    end

    // busy maps: set on connect, cleared on disconnect
    always_ff @(posedge clk) begin : busy_tables
        if (!rst_n) begin
            ib_q <= '0;
            ob_q <= '0;
            mb_q <= '0;
        end else if (do_conn) begin
            ib_q[cmd_in_port][sel_k]         <= 1'b1;
            ob_q[cmd_out_port][sel_k]        <= 1'b1;
            mb_q[cmd_out_port][cmd_out_slot] <= 1'b1;
        end else if (do_disc) begin
            ib_q[disc_p][disc_k]             <= 1'b0;
            ob_q[cmd_out_port][disc_k]       <= 1'b0;
            mb_q[cmd_out_port][cmd_out_slot] <= 1'b0;
        end
    end

    // path payload written with a new connection, no reset needed
    always_ff @(posedge clk) begin : path_tables
        if (do_conn) begin
            isl_q[cmd_in_port][sel_k]        <= cmd_in_slot;
            opt_q[cmd_out_port][sel_k]       <= cmd_in_port;
            osl_q[cmd_out_port][sel_k]       <= cmd_out_slot;
            mk_q[cmd_out_port][cmd_out_slot] <= sel_k;
        end
    end

    // command response, one cycle after the command
    always_ff @(posedge clk) begin : response
        if (!rst_n) begin
            rsp_vld      <= 1'b0;
            rsp_status   <= ST_OK;
            rsp_int_slot <= '0;
        end else begin
            rsp_vld      <= cmd_vld;
            rsp_status   <= st;
            rsp_int_slot <= sel_k;
        end
    end

    // per-link view of the tables for the internal slot now in progress
    always_comb begin : slot_view
        for (int q = 0; q < NPORT; q++) begin
            rd_addr[q] = isl_q[q][pos];
            xp_en[q]   = ob_q[q][pos];
            xp_sel[q]  = opt_q[q][pos];
            wr_addr[q] = osl_q[q][pos];
        end
        oslot_busy = mb_q;
    end

    p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> rsp_vld);
    p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> !rsp_vld);
    p_refuse_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_status != ST_OK) |->
        ($stable(ib_q) && $stable(ob_q) && $stable(mb_q)));

    for (genvar q = 0; q < NPORT; q++) begin : g_chk_q
        for (genvar k = 0; k < NLINK; k++) begin : g_chk_k
            // an outlet link slot in use always has its inlet link slot in use
            p_link_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ob_q[q][k] |-> ib_q[opt_q[q][k]][k]);
        end
        for (genvar s = 0; s < NSLOT; s++) begin : g_chk_s
            // a busy output slot points at a busy internal slot that maps back
            p_out_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
                mb_q[q][s] |-> (ob_q[q][mk_q[q][s]] && osl_q[q][mk_q[q][s]] == SW'(s)));
        end
    end

endmodule

// File: rtl/tst_switch.sv
// Time-space-time switching fabric, top level.
// Keeps the frame position and parity, and wires per-port input
// interchangers, the crosspoint, per-port output interchangers and the
// control engine. A frame is NLINK cycles; external slots use positions
// 0..NSLOT-1. Assumes: NLINK >= NSLOT, NPORT and NSLOT are powers of two.
module tst_switch
    import tst_pkg::*;
#(
    parameter int NPORT              = 4,
    parameter int NSLOT              = 8,
    parameter int NLINK              = 2 * NSLOT - 1,
    parameter int DW                 = 8,
    parameter logic [DW-1:0] IDLE_BYTE = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_fs,
    input  logic [NPORT-1:0][DW-1:0]      in_data,
    output logic                          out_fs,
    output logic [NPORT-1:0][DW-1:0]      out_data,
    input  logic                          cmd_vld,
    input  logic                          cmd_op,
    input  logic                          cmd_auto,
    input  logic [$clog2(NPORT)-1:0]      cmd_in_port,
    input  logic [$clog2(NSLOT)-1:0]      cmd_in_slot,
    input  logic [$clog2(NPORT)-1:0]      cmd_out_port,
    input  logic [$clog2(NSLOT)-1:0]      cmd_out_slot,
    input  logic [$clog2(NLINK)-1:0]      cmd_int_slot,
    output logic                          rsp_vld,
    output logic [1:0]                    rsp_status,
    output logic [$clog2(NLINK)-1:0]      rsp_int_slot
);

    localparam int PTW = $clog2(NPORT);
    localparam int SW  = $clog2(NSLOT);
    localparam int KW  = $clog2(NLINK);

    logic [KW-1:0] cnt_q;
    logic [KW-1:0] pos;
    logic          ph_q;
    logic          ph;
    logic          ext_act;
    logic [SW-1:0] ext_slot;

    logic [NPORT-1:0][DW-1:0]   link_in;
    logic [NPORT-1:0][DW-1:0]   link_out;
    logic [NPORT-1:0][SW-1:0]   rd_addr;
    logic [NPORT-1:0][SW-1:0]   wr_addr;
    logic [NPORT-1:0][PTW-1:0]  xp_sel;
    logic [NPORT-1:0]           xp_en;
    logic [NPORT-1:0][NSLOT-1:0] oslot_busy;

    // current frame position and bank parity; in_fs forces position 0
    always_comb begin : frame_pos
        pos      = in_fs ? '0 : cnt_q;
        ph       = (pos == '0) ? ~ph_q : ph_q;
        ext_act  = int'(pos) < NSLOT;
        ext_slot = pos[SW-1:0];
    end

    // advance the position counter and remember the frame parity
    always_ff @(posedge clk) begin : frame_cnt
        if (!rst_n) begin
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else begin
            cnt_q <= (pos == KW'(NLINK - 1)) ? '0 : pos + 1'b1;
            ph_q  <= ph;
        end
    end

    // output frame strobe, aligned with the registered output bytes
    always_ff @(posedge clk) begin : fs_reg
        if (!rst_n) begin
            out_fs <= 1'b0;
        end else begin
            out_fs <= (pos == '0);
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_in
        tst_in_tsi #(.NSLOT(NSLOT), .DW(DW)) u_in_tsi (
            .clk     (clk),
            .ph      (ph),
            .wr_en   (ext_act),
            .wr_slot (ext_slot),
            .din     (in_data[p]),
            .rd_addr (rd_addr[p]),
            .dout    (link_in[p])
        );
    end

    tst_space #(.NPORT(NPORT), .DW(DW)) u_space (
        .link_in  (link_in),
        .sel      (xp_sel),
        .en       (xp_en),
        .link_out (link_out)
    );

    for (genvar q = 0; q < NPORT; q++) begin : g_out
        tst_out_tsi #(.NSLOT(NSLOT), .DW(DW), .IDLE_BYTE(IDLE_BYTE)) u_out_tsi (
            .clk       (clk),
            .rst_n     (rst_n),
            .ph        (ph),
            .wr_en     (xp_en[q]),
            .wr_addr   (wr_addr[q]),
            .wr_data   (link_out[q]),
            .rd_act    (ext_act),
            .rd_slot   (ext_slot),
            .slot_busy (oslot_busy[q][ext_slot]),
            .dout      (out_data[q])
        );
    end

    tst_ctrl #(.NPORT(NPORT), .NSLOT(NSLOT), .NLINK(NLINK)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_vld      (cmd_vld),
        .cmd_op       (cmd_op),
        .cmd_auto     (cmd_auto),
        .cmd_in_port  (cmd_in_port),
        .cmd_in_slot  (cmd_in_slot),
        .cmd_out_port (cmd_out_port),
        .cmd_out_slot (cmd_out_slot),
        .cmd_int_slot (cmd_int_slot),
        .pos          (pos),
        .rd_addr      (rd_addr),
        .xp_en        (xp_en),
        .xp_sel       (xp_sel),
        .wr_addr      (wr_addr),
        .oslot_busy   (oslot_busy),
        .rsp_vld      (rsp_vld),
        .rsp_status   (rsp_status),
        .rsp_int_slot (rsp_int_slot)
    );

    p_fs_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_fs |=> out_fs);

endmodule

// File: tb/tst_switch_tb.sv
// Directed bench for the time-space-time fabric.
module tst_switch_tb;
    import tst_pkg::*;

    localparam int NP = 4;
    localparam int NS = 8;
    localparam int NL = 2 * NS - 1;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                  rst_n = 1'b0;
    logic                  in_fs;
    logic [NP-1:0][DW-1:0] in_data;
    logic                  out_fs;
    logic [NP-1:0][DW-1:0] out_data;
    logic                  cmd_vld = 1'b0, cmd_op = 1'b0, cmd_auto = 1'b0;
    logic [1:0]            cmd_in_port = '0, cmd_out_port = '0;
    logic [2:0]            cmd_in_slot = '0, cmd_out_slot = '0;
    logic [3:0]            cmd_int_slot = '0;
    logic                  rsp_vld;
    logic [1:0]            rsp_status;
    logic [3:0]            rsp_int_slot;

    int  bpos = 0, bfr = 0;
    bit  resync = 0, no_fs = 0;
    logic smp_rst;
    int  n_chk = 0, n_fail = 0;

    tst_switch u_dut (
        .clk(clk), .rst_n(rst_n), .in_fs(in_fs), .in_data(in_data),
        .out_fs(out_fs), .out_data(out_data),
        .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_auto(cmd_auto),
        .cmd_in_port(cmd_in_port), .cmd_in_slot(cmd_in_slot),
        .cmd_out_port(cmd_out_port), .cmd_out_slot(cmd_out_slot),
        .cmd_int_slot(cmd_int_slot),
        .rsp_vld(rsp_vld), .rsp_status(rsp_status), .rsp_int_slot(rsp_int_slot)
    );

    // byte tagged with frame, port and slot
    function automatic logic [7:0] pat(int fr, int p, int s);
        return {3'(fr), 2'(p), 3'(s)};
    endfunction

    task automatic drive_now();
        in_fs = (bpos == 0) && !no_fs;
        for (int p = 0; p < NP; p++) in_data[p] = (bpos < NS) ? pat(bfr, p, bpos) : 8'h00;
    endtask

    // stream source: one frame position per cycle, changed after the edge
    initial begin
        drive_now();
        forever begin
            @(posedge clk);
            smp_rst = rst_n;
            #1;
            if (!smp_rst) begin bpos = 0; bfr = 0; end
            else if (resync || bpos == NL - 1) begin bpos = 0; bfr++; resync = 0; end
            else bpos++;
            drive_now();
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_vld = 1'b0; no_fs = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_pos(int p);
        do @(negedge clk); while (bpos != p);
    endtask

    task automatic settle();
        repeat (3 * NL) @(negedge clk);
    endtask

    task automatic cmd(logic op, logic au, int ip, int is, int oq, int os, int k,
                       tst_status_e est, int ek, string tag);
        @(negedge clk);
        cmd_vld = 1'b1; cmd_op = op; cmd_auto = au;
        cmd_in_port = 2'(ip); cmd_in_slot = 3'(is);
        cmd_out_port = 2'(oq); cmd_out_slot = 3'(os); cmd_int_slot = 4'(k);
        @(negedge clk);
        cmd_vld = 1'b0;
        chk({tag, " R10 rsp_vld"}, 32'(rsp_vld), 32'd1);
        chk({tag, " status"}, 32'(rsp_status), 32'(est));
        if (ek >= 0) chk({tag, " int slot"}, 32'(rsp_int_slot), 32'(ek));
        @(negedge clk);
        chk({tag, " R10 single pulse"}, 32'(rsp_vld), 32'd0);
    endtask

    // output slot so of port q: source (sp, ss) or idle when sp < 0
    task automatic see(int q, int so, int sp, int ss, string tag);
        wait_pos(so + 1);
        chk(tag, 32'(out_data[q]), sp < 0 ? 32'hFF : 32'(pat(bfr - 2, sp, ss)));
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int q = 0; q < NP; q++) chk("R9 reset out_data", 32'(out_data[q]), 32'hFF);
        chk("R9 reset out_fs", 32'(out_fs), 32'd0);
        chk("R9 reset rsp_vld", 32'(rsp_vld), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_frame();
        do_reset();
        wait_pos(1); chk("R1 out_fs after position 0", 32'(out_fs), 32'd1);
        wait_pos(5); chk("R1 out_fs mid frame", 32'(out_fs), 32'd0);
        resync = 1;                       // early frame start at position 6
        wait_pos(1); chk("R1 out_fs after early in_fs", 32'(out_fs), 32'd1);
        wait_pos(3); no_fs = 1;           // free-running from here
        wait_pos(1); chk("R1 out_fs free running", 32'(out_fs), 32'd1);
        wait_pos(2); chk("R1 out_fs single cycle", 32'(out_fs), 32'd0);
        no_fs = 0;
    endtask

    task automatic t_path();
        do_reset();
        cmd(OP_CONNECT, 0, 1, 4, 2, 6, 12, ST_OK, 12, "R3 manual slot 12");
        cmd(OP_CONNECT, 1, 0, 2, 3, 0, 0, ST_OK, 0, "R5 auto first");
        cmd(OP_CONNECT, 1, 0, 2, 1, 7, 0, ST_OK, 1, "R5 auto skips inlet busy");
        settle();
        see(3, 0, 0, 2, "R2 port0 s2 to port3 s0");
        see(2, 0, -1, 0, "R9 idle slot port2 s0");
        see(2, 6, 1, 4, "R3 port1 s4 to port2 s6 via 12");
        see(1, 7, 0, 2, "R2 multicast port1 s7");
        see(1, 9, -1, 0, "R9 position beyond external frame");
        see(2, 6, 1, 4, "R2 next frame");
    endtask

    task automatic t_refuse();
        do_reset();
        cmd(OP_CONNECT, 0, 0, 1, 1, 2, 3, ST_OK, 3, "R4 setup");
        cmd(OP_CONNECT, 0, 0, 5, 2, 1, 3, ST_BLOCKED, -1, "R4 inlet busy");
        cmd(OP_CONNECT, 0, 3, 5, 1, 4, 3, ST_BLOCKED, -1, "R4 outlet busy");
        cmd(OP_CONNECT, 1, 2, 2, 1, 2, 0, ST_OUT_BUSY, -1, "R7 slot in use");
        settle();
        see(2, 1, -1, 0, "R4 refused slot stays idle");
        see(1, 2, 0, 1, "R7 existing path kept");
        see(1, 4, -1, 0, "R4 refused outlet slot idle");
    endtask

    task automatic t_nonblock();
        do_reset();
        for (int k = 0; k < NS - 1; k++)
            cmd(OP_CONNECT, 0, 0, k, 1, k, k, ST_OK, k, "R11 load inlet");
        for (int k = 0; k < NS - 1; k++)
            cmd(OP_CONNECT, 0, 2, k, 3, k, NS - 1 + k, ST_OK, NS - 1 + k, "R11 load outlet");
        cmd(OP_CONNECT, 1, 0, 7, 3, 7, 0, ST_OK, NL - 1, "R11 last free slot");
        settle();
        see(3, 2, 2, 2, "R2 outlet load path");
        see(1, 3, 0, 3, "R2 inlet load path");
        see(3, 7, 0, 7, "R11 path through slot 14");
    endtask

    task automatic t_exhaust();
        do_reset();
        for (int k = 0; k < NL; k++)
            cmd(OP_CONNECT, 0, 1, k % NS, (k < NS) ? 0 : 2, k % NS, k, ST_OK, k, "R6 fill inlet");
        cmd(OP_CONNECT, 1, 1, 0, 3, 0, 0, ST_BLOCKED, -1, "R6 auto blocked");
        cmd(OP_CONNECT, 0, 1, 0, 3, 1, 5, ST_BLOCKED, -1, "R4 manual on full link");
        settle();
        see(3, 0, -1, 0, "R6 blocked slot idle");
        see(2, 5, 1, 5, "R2 multicast fill path");
    endtask

    task automatic t_disc();
        do_reset();
        cmd(OP_CONNECT, 1, 0, 1, 1, 3, 0, ST_OK, 0, "R8 setup");
        settle();
        see(1, 3, 0, 1, "R8 connected before release");
        cmd(OP_DISCONNECT, 0, 0, 0, 1, 3, 0, ST_OK, 0, "R8 release");
        cmd(OP_DISCONNECT, 0, 0, 0, 1, 3, 0, ST_NOT_CONN, -1, "R8 release idle");
        cmd(OP_CONNECT, 1, 0, 4, 2, 0, 0, ST_OK, 0, "R8 inlet freed");
        cmd(OP_CONNECT, 1, 3, 6, 1, 6, 0, ST_OK, 0, "R8 outlet freed");
        settle();
        see(1, 3, -1, 0, "R8 released slot idle");
        see(1, 6, 3, 6, "R8 reuse on outlet");
    endtask

    initial begin
        t_reset();
        t_frame();
        t_path();
        t_refuse();
        t_nonblock();
        t_exhaust();
        t_disc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule